// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM of 128 words of 16 bits. A processor reaches it through one 8-bit register and bit-bangs the protocol itself. Each write to the register sets the select, clock and data-in lines. Each read of the register returns those three lines together with the data-out line. The block watches the software clock bit for rising and falling edges. It recognises a start bit, shifts in a 2-bit opcode and an 8-bit address field, and then carries out one of these commands: word read, word write, word erase, write-all, erase-all, write-enable and write-disable.

The register is hidden behind a two-step unlock. One configuration write arms the block and a second opens the serial register. While the block is locked, reads of the register return 0xFF and writes to it have no effect. The storage is held in flip-flops and every word comes out of reset in the erased state.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the block is locked, so `ser_rdata` reads 0xFF. Every word reads back as 0xFFFF and the write-enable latch is clear.
- R2: The serial register is visible only while two conditions both hold. The last write on the arm port (`cfg_sel`=0) carried 0x0A, and the last write on the open port (`cfg_sel`=1) carried 0x40. Any other value on the arm port clears both conditions, and any other value on the open port clears the second. While the register is hidden, `ser_rdata` is 0xFF and `ser_we` changes no state.
- R3: The register layout is: bit 7 select, bit 6 serial clock, bit 1 data-in, bit 0 data-out. All other bits read 0. The bits written read back on the next cycle. After reset the register reads 0x01.
- R4: Bits are taken on the rising edge of the clock bit. In idle, a rising edge with data-in at 1 is the start bit. The next 10 edges shift in, MSB first, a 2-bit opcode and then an 8-bit address field. Only the low 7 bits of the address field pick the word, so field 0x83 addresses word 3.
- R5: Opcode 10 is a read. On the edge that completes the command, data-out drives a 0 dummy bit. The next 16 rising edges each drive one bit of the word, MSB first. After the 16th bit the block returns to idle.
- R6: Opcode 01 is a write. It takes 16 further data bits, MSB first, and stores them at the addressed word only if the write-enable latch is set.
- R7: Opcode 11 is an erase. It sets the addressed word to 0xFFFF, only when the write-enable latch is set.
- R8: Opcode 00 takes the top two bits of the address field as a sub-command: 00 clears the write-enable latch, 11 sets it, 10 erases all words, and 01 takes 16 data bits and writes them to all words. Erase-all and write-all apply only when the latch is set.
- R9: On a register write that lowers the clock bit while select stays high, data-out keeps its value. On any other write that is not a rising clock edge, and on rising edges outside a read, data-out reads 1.
- R10: A rising edge on the select bit returns the command decoder to idle, discarding any partly shifted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = arm port, 1 = open port |
| cfg_data | input | 8 | Configuration write data |
| ser_we | input | 1 | Serial register write strobe |
| ser_wdata | input | 8 | Serial register write data (select, clock, data-in) |
| ser_rdata | output | 8 | Serial register read value, 0xFF while hidden |

## Verification
A behavioural model of the protocol is stepped alongside the design, and the register read value is compared on every cycle. Directed command streams are also run. Reads of erased, written and aliased addresses (0x03 and 0x83) separate correct address masking from a wrong word select. Writes and erases issued with the latch clear, then set, then cleared again show whether the latch gates storage. Write-all followed by reads of the first, middle and last words shows whether the broadcast reaches every word. Full command streams sent while the block is locked, and a command cut short by a new select edge, check that ignored or aborted input leaves no trace in later reads.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  // register bit positions as seen by software
  localparam int CS_BIT  = 7;
  localparam int SCK_BIT = 6;
  localparam int DI_BIT  = 1;
  localparam int DO_BIT  = 0;

  // opcodes (first two bits after the start bit)
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // sub-commands under OP_EXT
  localparam logic [1:0] EX_LOCK  = 2'b00;
  localparam logic [1:0] EX_FILL  = 2'b01;
  localparam logic [1:0] EX_WIPE  = 2'b10;
  localparam logic [1:0] EX_ALLOW = 2'b11;

  localparam logic [7:0] ARM_KEY  = 8'h0A;
  localparam logic [7:0] OPEN_KEY = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_SHOUT = 3'd2,
    ST_WORD  = 3'd3,
    ST_FILL  = 3'd4
  } ser_state_t;
endpackage

// File: rtl/tw_access_gate.sv
module tw_access_gate
  import tw_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_data,
  output logic       visible
);
  logic arm_q, arm_d;
  logic open_q, open_d;

  always_comb begin
    arm_d  = arm_q;
    open_d = open_q;
    if (cfg_we) begin
      if (!cfg_sel) begin
        arm_d = (cfg_data == ARM_KEY);
        if (cfg_data != ARM_KEY) open_d = 1'b0;
      end else begin
        open_d = (cfg_data == OPEN_KEY);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      open_q <= open_d;
    end
  end

  assign visible = arm_q & open_q;

  // R2
  bad_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_data != ARM_KEY) |=> !visible);

  // R2
  bad_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && cfg_data != OPEN_KEY) |=> !visible);
endmodule

// File: rtl/tw_word_store.sv
module tw_word_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = we_all | (we_one & (wr_addr == AW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '1;
      end else if (hit) begin
        mem_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R6
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one && !we_all) |=> mem_q[$past(wr_addr)] == $past(wr_data));

  // R8
  all_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_all |=> (mem_q[0] == $past(wr_data)) && (mem_q[WORDS-1] == $past(wr_data)));

  // R8
  write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_one, we_all}));
endmodule

// File: rtl/tw_serial_fsm.sv
module tw_serial_fsm
  import tw_eeprom_pkg::*;
#(
  parameter int WORDS   = 128,
  parameter int WORD_W  = 16,
  parameter int AFLD_W  = 8,
  localparam int AW       = $clog2(WORDS),
  localparam int CMD_BITS = 2 + AFLD_W,
  localparam int SR_W     = (WORD_W > CMD_BITS) ? WORD_W : CMD_BITS,
  localparam int CNT_W    = $clog2(SR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [7:0]        wdata,
  input  logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     rd_addr,
  output logic              we_one,
  output logic              we_all,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wen,
  output logic [7:0]        reg_val
);
  ser_state_t       st_q, st_d;
  logic [SR_W-1:0]  sr_q, sr_d, sr_sh;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [AW-1:0]    addr_q, addr_d, cmd_addr;
  logic             wen_q, wen_d;
  logic             cs_q, cs_d, sck_q, sck_d, di_q, di_d, do_q, do_d;
  logic [1:0]       op_w, ext_w;
  logic             sck_rise;

  assign sr_sh    = {sr_q[SR_W-2:0], wdata[DI_BIT]};
  assign cnt_inc  = cnt_q + 1'b1;
  assign op_w     = sr_sh[CMD_BITS-1 -: 2];
  assign ext_w    = sr_sh[CMD_BITS-3 -: 2];
  assign cmd_addr = sr_sh[AW-1:0];
  assign rd_addr  = cmd_addr;
  assign sck_rise = !sck_q && wdata[SCK_BIT];

  always_comb begin
    st_d    = st_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    wen_d   = wen_q;
    cs_d    = cs_q;
    sck_d   = sck_q;
    di_d    = di_q;
    do_d    = do_q;
    we_one  = 1'b0;
    we_all  = 1'b0;
    wr_addr = addr_q;
    wr_data = '1;
    if (acc_wr) begin
      cs_d  = wdata[CS_BIT];
      sck_d = wdata[SCK_BIT];
      di_d  = wdata[DI_BIT];
      do_d  = 1'b1;
      if (!cs_q && cs_d) st_d = ST_IDLE;
      if (sck_rise) begin
        if (st_d == ST_CMD || st_d == ST_WORD || st_d == ST_FILL) begin
          sr_d  = sr_sh;
          cnt_d = cnt_inc;
        end
        case (st_d)
          ST_IDLE: begin
            if (wdata[DI_BIT]) begin
              st_d  = ST_CMD;
              cnt_d = '0;
              sr_d  = '0;
            end
          end
          ST_CMD: begin
            if (cnt_d == CNT_W'(CMD_BITS)) begin
              cnt_d  = '0;
              addr_d = cmd_addr;
              case (op_w)
                OP_WRITE: st_d = ST_WORD;
                OP_READ: begin
                  st_d  = ST_SHOUT;
                  cnt_d = CNT_W'(WORD_W);
                  sr_d  = SR_W'(rd_word);
                  do_d  = 1'b0;
                end
                OP_ERASE: begin
                  we_one  = wen_q;
                  wr_addr = cmd_addr;
                  st_d    = ST_IDLE;
                end
                default: begin
                  st_d = ST_IDLE;
                  case (ext_w)
                    EX_LOCK:  wen_d  = 1'b0;
                    EX_ALLOW: wen_d  = 1'b1;
                    EX_WIPE:  we_all = wen_q;
                    default:  st_d   = ST_FILL;
                  endcase
                end
              endcase
            end
          end
          ST_SHOUT: begin
            do_d  = sr_q[WORD_W-1];
            sr_d  = sr_q << 1;
            cnt_d = cnt_q - 1'b1;
            if (cnt_d == '0) st_d = ST_IDLE;
          end
          ST_WORD, ST_FILL: begin
            if (cnt_d == CNT_W'(WORD_W)) begin
              wr_data = sr_d[WORD_W-1:0];
              if (st_d == ST_WORD) we_one = wen_q;
              else                 we_all = wen_q;
              st_d = ST_IDLE;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end else if (cs_d && sck_q && !sck_d) begin
        do_d = do_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      wen_q  <= 1'b0;
      cs_q   <= 1'b0;
      sck_q  <= 1'b0;
      di_q   <= 1'b0;
      do_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      wen_q  <= wen_d;
      cs_q   <= cs_d;
      sck_q  <= sck_d;
      di_q   <= di_d;
      do_q   <= do_d;
    end
  end

  assign wen     = wen_q;
  assign reg_val = {cs_q, sck_q, 4'b0000, di_q, do_q};

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable({cs_q, sck_q, di_q, do_q, st_q, wen_q}));

  // R9
  do_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && cs_q && wdata[CS_BIT] && sck_q && !wdata[SCK_BIT]) |=> $stable(do_q));

  // R10
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !cs_q && wdata[CS_BIT] && !sck_rise) |=> st_q == ST_IDLE);

  // R5
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && sck_rise && st_q == ST_CMD && !(!cs_q && wdata[CS_BIT])
     && cnt_inc == CNT_W'(CMD_BITS) && op_w == OP_READ)
    |=> (st_q == ST_SHOUT) && !do_q);

  // R5
  shout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHOUT) |-> cnt_q != '0);
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_eeprom_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 16,
  parameter int AFLD_W = 8,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_data,
  input  logic       ser_we,
  input  logic [7:0] ser_wdata,
  output logic [7:0] ser_rdata
);
  logic              visible;
  logic              we_one, we_all, wen;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_data, rd_word;
  logic [7:0]        reg_val;

  tw_access_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .visible  (visible)
  );

  tw_serial_fsm #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W),
    .AFLD_W (AFLD_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_wr  (ser_we & visible),
    .wdata   (ser_wdata),
    .rd_word (rd_word),
    .rd_addr (rd_addr),
    .we_one  (we_one),
    .we_all  (we_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wen     (wen),
    .reg_val (reg_val)
  );

  tw_word_store #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_one  (we_one),
    .we_all  (we_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  assign ser_rdata = visible ? reg_val : 8'hFF;

  // R6
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> wen);

  // R2
  hidden_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> (ser_we && visible));
endmodule

// File: tb/tw_eeprom_test.sv
module tw_eeprom_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       ser_we = 1'b0;
  logic [7:0] ser_wdata = 8'h00;
  logic [7:0] ser_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tw_eeprom uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .ser_we(ser_we), .ser_wdata(ser_wdata),
    .ser_rdata(ser_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_mem [128];
  int m_arm, m_open, m_cs, m_sk, m_di, m_do, m_st, m_sr, m_cnt, m_addr, m_wen;
  // states: 0 idle, 1 command, 2 shifting out, 3 word data, 4 fill data

  task automatic m_serial(input logic [7:0] b);
    int ncs = b[7];
    int nsk = b[6];
    int ndi = b[1];
    int ndo = 1;
    int op, ex;
    if (!m_cs && ncs) m_st = 0;
    if (!m_sk && nsk) begin
      if (m_st == 1 || m_st == 3 || m_st == 4) begin
        m_sr = ((m_sr << 1) | ndi) & 16'hFFFF;
        m_cnt++;
      end
      if (m_st == 0) begin
        if (ndi) begin m_st = 1; m_cnt = 0; m_sr = 0; end
      end else if (m_st == 1) begin
        if (m_cnt == 10) begin
          m_cnt = 0; m_addr = m_sr % 128;
          op = (m_sr >> 8) & 3; ex = (m_sr >> 6) & 3;
          if (op == 1) m_st = 3;
          else if (op == 2) begin m_sr = m_mem[m_addr]; m_cnt = 16; m_st = 2; ndo = 0; end
          else if (op == 3) begin if (m_wen) m_mem[m_addr] = 16'hFFFF; m_st = 0; end
          else begin
            m_st = 0;
            if (ex == 0) m_wen = 0;
            else if (ex == 3) m_wen = 1;
            else if (ex == 1) m_st = 4;
            else if (m_wen) foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
          end
        end
      end else if (m_st == 2) begin
        ndo = (m_sr >> 15) & 1;
        m_sr = (m_sr << 1) & 16'hFFFF;
        m_cnt--;
        if (m_cnt == 0) m_st = 0;
      end else if (m_cnt == 16) begin
        if (m_wen) begin
          if (m_st == 3) m_mem[m_addr] = m_sr;
          else foreach (m_mem[i]) m_mem[i] = m_sr;
        end
        m_st = 0;
      end
    end else if (ncs && m_sk && !nsk) begin
      ndo = m_do;
    end
    m_cs = ncs; m_sk = nsk; m_di = ndi; m_do = ndo;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_open = 0; m_cs = 0; m_sk = 0; m_di = 0; m_do = 1;
      m_st = 0; m_sr = 0; m_cnt = 0; m_addr = 0; m_wen = 0;
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
    end else begin
      if (ser_we && m_arm && m_open) m_serial(ser_wdata);
      if (cfg_we) begin
        if (!cfg_sel) begin
          m_arm = (cfg_data == 8'h0A);
          if (cfg_data != 8'h0A) m_open = 0;
        end else m_open = (cfg_data == 8'h40);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison of the register read value (R3)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp;
      exp = (m_arm && m_open) ? {m_cs[0], m_sk[0], 4'b0000, m_di[0], m_do[0]} : 8'hFF;
      check("R3 model", ser_rdata, exp);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] b);
    ser_we = 1'b1; ser_wdata = b;
    @(negedge clk);
    ser_we = 1'b0;
  endtask

  task automatic cfg(input logic sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clk_bit(input logic di, output logic dout);
    wr({1'b1, 1'b0, 4'b0000, di, 1'b0});
    wr({1'b1, 1'b1, 4'b0000, di, 1'b0});
    dout = ser_rdata[0];
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] a, output logic dout);
    logic d;
    wr(8'h00);
    wr(8'h80);
    clk_bit(1'b1, d);
    clk_bit(op[1], d);
    clk_bit(op[0], d);
    for (int i = 7; i >= 0; i--) clk_bit(a[i], d);
    dout = d;
  endtask

  task automatic send_data(input logic [15:0] w);
    logic d;
    for (int i = 15; i >= 0; i--) clk_bit(w[i], d);
    wr(8'h00);
  endtask

  task automatic ee_read(input logic [7:0] a, output logic [15:0] w, output logic dummy);
    logic d;
    send_cmd(2'b10, a, dummy);
    w = '0;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, d);
      w[i] = d;
    end
    wr(8'h00);
  endtask

  task automatic ee_write(input logic [7:0] a, input logic [15:0] w);
    logic d;
    send_cmd(2'b01, a, d);
    send_data(w);
  endtask

  task automatic ee_ext(input logic [1:0] sub);
    logic d;
    send_cmd(2'b00, {sub, 6'b0}, d);
    wr(8'h00);
  endtask

  task automatic ee_erase(input logic [7:0] a);
    logic d;
    send_cmd(2'b11, a, d);
    wr(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic dm, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 locked after reset", ser_rdata, 8'hFF);

    cfg(1'b0, 8'h0A);
    check("R2 arm alone stays hidden", ser_rdata, 8'hFF);
    cfg(1'b1, 8'h40);
    check("R3 reset register value", ser_rdata, 8'h01);

    wr(8'h82);
    check("R3 select and data-in read back", ser_rdata, 8'h83);
    wr(8'h00);

    ee_read(8'h05, w, dm);
    check("R1 erased word after reset", w, 16'hFFFF);
    check("R5 dummy bit", dm, 0);
    check("R5 idle after read", ser_rdata[0], 1);

    ee_write(8'h03, 16'h1234);
    ee_read(8'h03, w, dm);
    check("R6 write ignored with latch clear", w, 16'hFFFF);

    ee_ext(2'b11);
    ee_write(8'h03, 16'h1234);
    ee_read(8'h03, w, dm);
    check("R6 write with latch set", w, 16'h1234);
    ee_read(8'h83, w, dm);
    check("R4 address field masked to 7 bits", w, 16'h1234);

    ee_write(8'h7F, 16'h8001);
    send_cmd(2'b10, 8'h7F, dm);
    clk_bit(1'b0, d);
    check("R5 first bit is MSB", d, 1);
    wr(8'h80);
    check("R9 falling clock holds data-out", ser_rdata[0], 1);
    wr(8'h80);
    check("R9 no edge drives 1", ser_rdata[0], 1);
    for (int i = 14; i >= 0; i--) clk_bit(1'b0, d);
    check("R5 last bit of word", d, 1);
    wr(8'h00);
    ee_read(8'h7F, w, dm);
    check("R4 top word", w, 16'h8001);

    ee_erase(8'h03);
    ee_read(8'h03, w, dm);
    check("R7 erase", w, 16'hFFFF);

    send_cmd(2'b00, 8'h40, d);
    send_data(16'hA5C3);
    ee_read(8'h00, w, dm);
    check("R8 write-all word 0", w, 16'hA5C3);
    ee_read(8'h40, w, dm);
    check("R8 write-all word 64", w, 16'hA5C3);
    ee_read(8'h7F, w, dm);
    check("R8 write-all word 127", w, 16'hA5C3);

    ee_ext(2'b10);
    ee_read(8'h40, w, dm);
    check("R8 erase-all", w, 16'hFFFF);

    send_cmd(2'b00, 8'h40, d);
    send_data(16'h0F0F);
    ee_ext(2'b00);
    ee_write(8'h0A, 16'h5555);
    ee_erase(8'h0A);
    ee_read(8'h0A, w, dm);
    check("R8 write-disable blocks writes", w, 16'h0F0F);

    cfg(1'b1, 8'h00);
    check("R2 closed port hides register", ser_rdata, 8'hFF);
    ee_ext(2'b11);
    ee_write(8'h0A, 16'h1111);
    cfg(1'b1, 8'h40);
    ee_read(8'h0A, w, dm);
    check("R2 hidden writes ignored", w, 16'h0F0F);

    cfg(1'b0, 8'h0B);
    cfg(1'b0, 8'h0A);
    check("R2 bad arm value clears open", ser_rdata, 8'hFF);
    cfg(1'b1, 8'h40);

    wr(8'h00);
    wr(8'h80);
    clk_bit(1'b1, d);
    clk_bit(1'b1, d);
    clk_bit(1'b1, d);
    wr(8'h00);
    ee_read(8'h0A, w, dm);
    check("R10 select edge aborts partial command", w, 16'h0F0F);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule